// File: doc/BRIEF.md
# Three-Port Register-Mapped Parallel I/O

This block gives a processor three byte-wide general-purpose I/O ports, called A, B and C, behind a small synchronous register bus. Each port keeps a data byte and a direction byte. A direction bit of 1 turns that pin into an output that drives the stored data bit. A direction bit of 0 turns it into an input, and the output bus shows a constant 1 in that position. Dedicated set-mask and clear-mask addresses change single pins in one bus write, with no read-modify-write.

Each port has an 8-bit pin output bus and an 8-bit pin input bus. The bus has a 5-bit offset, separate write and read strobes, and separate write and read data. Read data is registered and appears one cycle after the read strobe. The block also holds a byte-wide mode register, which software can only store and read back, and a read-only snapshot byte per port. A write to an offset that decodes to nothing changes no state and raises a one-cycle error pulse.

Offsets, with p = 0 for A, 1 for B and 2 for C:
- data 0x00+p
- direction 0x04+p
- mode 0x08
- clear-mask 0x0C+p
- set-mask 0x10+p
- snapshot 0x14+p, which is read-only

Top module: `gpio3_regs`

## Requirements
- R1: After reset all three pin output buses, `rdata` and `err` are 0, and a direction register reads 0.
- R2: A pin output register is updated on the clock edge of any write to that port's data, direction, set-mask or clear-mask offset. Its new value is (data AND dir) OR (NOT dir), computed from the values after the write. Until the first such write after reset the port drives 0.
- R3: A write to direction offset 0x04+p recomputes the driven pins from that port's current data byte.
- R4: A write to set-mask offset 0x10+p ORs `wdata` into the data byte of port p.
- R5: A write to clear-mask offset 0x0C+p clears every data bit of port p whose `wdata` bit is 1.
- R6: A read of data offset 0x00+p returns the pin input for direction-0 bits and the data byte for direction-1 bits. `rdata` changes only on the edge where `rd_en` is high, so the value is valid one cycle after the strobe and is held afterwards.
- R7: Snapshot offset 0x14+p reads the byte most recently written to data offset 0x00+p, ANDed with NOT dir as it stood at that write. Set-mask and clear-mask writes leave the snapshot unchanged.
- R8: Mode offset 0x08 stores and reads back all 8 bits and has no effect on any pin.
- R9: A write to any other offset, including the read-only snapshot offsets, changes no state. `err` is 1 for exactly the one cycle after that write. Mapped writes never raise `err`. A read of an offset with no readable register returns 0.
- R10: The three ports are independent: a write addressed to one port leaves the other ports' pin outputs and registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| err | output | 1 | One-cycle pulse after a write to an unmapped offset |
| pa_o | output | 8 | Port A pin outputs |
| pa_i | input | 8 | Port A pin inputs |
| pb_o | output | 8 | Port B pin outputs |
| pb_i | input | 8 | Port B pin inputs |
| pc_o | output | 8 | Port C pin outputs |
| pc_i | input | 8 | Port C pin inputs |

## Verification
A corrupted data or direction byte appears on the port's pin outputs on the clock edge that completes the next write touching that port. It also appears in the readback one cycle after a read strobe, so each fault can be seen within two cycles of the stimulus that exposes it. A wrong snapshot or mode byte stays hidden until it is read back, so the bench reads those registers after the writes that could have disturbed them. A decode fault shows as a wrong port moving, or as an `err` pulse that is missing or extra in the cycle after the write.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;
  localparam int NPORT    = 3;
  localparam int OFS_DATA = 'h00;
  localparam int OFS_DIR  = 'h04;
  localparam int OFS_MODE = 'h08;
  localparam int OFS_CLR  = 'h0C;
  localparam int OFS_SET  = 'h10;
  localparam int OFS_SNAP = 'h14;

  // Drive rule: output bits carry data, input bits are forced high.
  function automatic logic [7:0] drive8(input logic [7:0] d, input logic [7:0] m);
    return (d & m) | ~m;
  endfunction
endpackage

// File: rtl/gpio3_decode.sv
module gpio3_decode
  import gpio3_pkg::*;
#(
  parameter int AW = 5,
  parameter int NP = NPORT
) (
  input  logic [AW-1:0] addr,
  output logic [NP-1:0] hit_data,
  output logic [NP-1:0] hit_dir,
  output logic [NP-1:0] hit_clr,
  output logic [NP-1:0] hit_set,
  output logic [NP-1:0] hit_snap,
  output logic          hit_mode,
  output logic          wr_ok
);
  for (genvar p = 0; p < NP; p++) begin : g_hit
    assign hit_data[p] = (addr == AW'(OFS_DATA + p));
    assign hit_dir[p]  = (addr == AW'(OFS_DIR  + p));
    assign hit_clr[p]  = (addr == AW'(OFS_CLR  + p));
    assign hit_set[p]  = (addr == AW'(OFS_SET  + p));
    assign hit_snap[p] = (addr == AW'(OFS_SNAP + p));
  end

  assign hit_mode = (addr == AW'(OFS_MODE));
  // Snapshot offsets are read-only, so they are not legal write targets.
  assign wr_ok    = hit_mode | (|hit_data) | (|hit_dir) | (|hit_clr) | (|hit_set);

  // R9
  always_comb begin
    decode_onehot_chk: assert ($countones({hit_data, hit_dir, hit_clr, hit_set, hit_snap, hit_mode}) <= 1)
      else $error("decode hits more than one register");
  end
endmodule

// File: rtl/gpio3_port.sv
module gpio3_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_data,
  input  logic          we_dir,
  input  logic          we_set,
  input  logic          we_clr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] rd_port,
  output logic [DW-1:0] dir_o,
  output logic [DW-1:0] snap_o
);
  logic [DW-1:0] data_q, dir_q, snap_q, pin_q;
  logic [DW-1:0] data_n, dir_n;
  logic          touched_q;
  logic          any_we;

  assign any_we = we_data | we_dir | we_set | we_clr;

  always_comb begin
    data_n = data_q;
    dir_n  = dir_q;
    if (we_data) data_n = wdata;
    if (we_set)  data_n = data_q | wdata;
    if (we_clr)  data_n = data_q & ~wdata;
    if (we_dir)  dir_n  = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      dir_q     <= '0;
      snap_q    <= '0;
      pin_q     <= '0;
      touched_q <= 1'b0;
    end else begin
      data_q <= data_n;
      dir_q  <= dir_n;
      if (we_data) snap_q <= wdata & ~dir_q;
      if (any_we) begin
        pin_q     <= (data_n & dir_n) | ~dir_n;
        touched_q <= 1'b1;
      end
    end
  end

  assign pin_o   = pin_q;
  assign dir_o   = dir_q;
  assign snap_o  = snap_q;
  assign rd_port = (pin_i & ~dir_q) | (data_q & dir_q);

  // R1
  untouched_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !touched_q |-> (pin_q == '0)) else $error("port drives before first write");
  // R2
  input_bits_high_chk: assert property (@(posedge clk) disable iff (rst)
    touched_q |-> ((pin_q | dir_q) == {DW{1'b1}})) else $error("input pin not high");
  // R4
  set_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (we_set && !we_data && !we_clr) |=> ((data_q & $past(wdata)) == $past(wdata)))
    else $error("set mask not applied");
  // R5
  clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (we_clr && !we_data && !we_set) |=> ((data_q & $past(wdata)) == '0))
    else $error("clear mask not applied");
  // R7
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_data |=> $stable(snap_q)) else $error("snapshot moved without data write");
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_we |=> ($stable(pin_q) && $stable(data_q) && $stable(dir_q)))
    else $error("port changed without its own write");
endmodule

// File: rtl/gpio3_regs.sv
module gpio3_regs
  import gpio3_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [DW-1:0] pa_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pb_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pc_o,
  input  logic [DW-1:0] pc_i
);
  localparam int NP = NPORT;

  logic [NP-1:0] hit_data, hit_dir, hit_clr, hit_set, hit_snap;
  logic          hit_mode, wr_ok;

  logic [DW-1:0] pin_in  [NP];
  logic [DW-1:0] pin_out [NP];
  logic [DW-1:0] rd_port [NP];
  logic [DW-1:0] dir_v   [NP];
  logic [DW-1:0] snap_v  [NP];

  logic [DW-1:0] mode_q, rdata_q, rd_next;
  logic          err_q;

  gpio3_decode #(.AW(AW), .NP(NP)) u_dec (
    .addr     (addr),
    .hit_data (hit_data),
    .hit_dir  (hit_dir),
    .hit_clr  (hit_clr),
    .hit_set  (hit_set),
    .hit_snap (hit_snap),
    .hit_mode (hit_mode),
    .wr_ok    (wr_ok)
  );

  assign pin_in[0] = pa_i;
  assign pin_in[1] = pb_i;
  assign pin_in[2] = pc_i;
  assign pa_o = pin_out[0];
  assign pb_o = pin_out[1];
  assign pc_o = pin_out[2];

  for (genvar p = 0; p < NP; p++) begin : g_port
    gpio3_port #(.DW(DW)) u_port (
      .clk     (clk),
      .rst     (rst),
      .we_data (wr_en & hit_data[p]),
      .we_dir  (wr_en & hit_dir[p]),
      .we_set  (wr_en & hit_set[p]),
      .we_clr  (wr_en & hit_clr[p]),
      .wdata   (wdata),
      .pin_i   (pin_in[p]),
      .pin_o   (pin_out[p]),
      .rd_port (rd_port[p]),
      .dir_o   (dir_v[p]),
      .snap_o  (snap_v[p])
    );
  end

  always_comb begin
    rd_next = '0;
    if (hit_mode) rd_next = mode_q;
    for (int p = 0; p < NP; p++) begin
      if (hit_data[p]) rd_next = rd_port[p];
      if (hit_dir[p])  rd_next = dir_v[p];
      if (hit_snap[p]) rd_next = snap_v[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (wr_en && hit_mode) mode_q <= wdata;
      if (rd_en) rdata_q <= rd_next;
      err_q <= wr_en & ~wr_ok;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;

  // R9
  err_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !err_q) else $error("error pulse without a write");
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_mode) |=> $stable(mode_q)) else $error("mode changed without its write");
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q)) else $error("read data moved without strobe");
endmodule

// File: tb/tb_gpio3_regs.sv
module tb_gpio3_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       err;
  logic [7:0] pa_o, pb_o, pc_o;
  logic [7:0] pa_i = '0, pb_i = '0, pc_i = '0;

  int n_run = 0;
  int n_fail = 0;
  logic last_err;

  gpio3_regs dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .err(err),
    .pa_o(pa_o), .pa_i(pa_i), .pb_o(pb_o), .pb_i(pb_i), .pc_o(pc_o), .pc_i(pc_i)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] drv(input logic [7:0] d, input logic [7:0] m);
    return (d & m) | ~m;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    last_err = err;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1", "pa_o", pa_o, 8'h00);
    chk("R1", "pb_o", pb_o, 8'h00);
    chk("R1", "pc_o", pc_o, 8'h00);
    chk("R1", "err", {7'd0, err}, 8'h00);
    chk("R1", "rdata", rdata, 8'h00);
    rd(5'h04, v);
    chk("R1", "dir A read", v, 8'h00);
  endtask

  task automatic t_drive();
    wr(5'h04, 8'hFF);
    chk("R2", "pa_o after dir write", pa_o, drv(8'h00, 8'hFF));
    wr(5'h00, 8'h5A);
    chk("R2", "pa_o all outputs", pa_o, 8'h5A);
    chk("R9", "err after mapped write", {7'd0, last_err}, 8'h00);
    chk("R10", "pb_o untouched", pb_o, 8'h00);
    chk("R10", "pc_o untouched", pc_o, 8'h00);
    wr(5'h05, 8'h0F);
    wr(5'h01, 8'hA5);
    chk("R2", "pb_o mixed", pb_o, drv(8'hA5, 8'h0F));
    chk("R10", "pa_o unchanged by B", pa_o, 8'h5A);
  endtask

  task automatic t_dir_recompute();
    wr(5'h04, 8'hF0);
    chk("R3", "pa_o after dir change", pa_o, drv(8'h5A, 8'hF0));
    wr(5'h04, 8'h00);
    chk("R3", "pa_o all inputs", pa_o, 8'hFF);
    wr(5'h04, 8'hF0);
  endtask

  task automatic t_setclr();
    logic [7:0] v;
    wr(5'h06, 8'hFF);
    wr(5'h02, 8'h00);
    wr(5'h12, 8'h81);
    chk("R4", "pc_o after set", pc_o, 8'h81);
    wr(5'h12, 8'h18);
    chk("R4", "pc_o second set", pc_o, 8'h99);
    wr(5'h0E, 8'h09);
    chk("R5", "pc_o after clear", pc_o, 8'h90);
    rd(5'h02, v);
    chk("R5", "port C readback", v, 8'h90);
    chk("R10", "pb_o unchanged by C", pb_o, drv(8'hA5, 8'h0F));
  endtask

  task automatic t_read();
    logic [7:0] v;
    pa_i = 8'h3C;
    rd(5'h00, v);
    chk("R6", "port A mixed read", v, (8'h3C & 8'h0F) | (8'h5A & 8'hF0));
    pa_i = 8'hC3;
    @(negedge clk);
    chk("R6", "rdata held", rdata, 8'h5C);
    rd(5'h00, v);
    chk("R6", "port A re-read", v, (8'hC3 & 8'h0F) | (8'h5A & 8'hF0));
  endtask

  task automatic t_snap();
    logic [7:0] v;
    rd(5'h15, v);
    chk("R7", "snapshot B", v, 8'hA5 & 8'hF0);
    wr(5'h11, 8'hFF);
    wr(5'h0D, 8'h0F);
    rd(5'h15, v);
    chk("R7", "snapshot B after set/clear", v, 8'hA0);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wr(5'h08, 8'h3C);
    rd(5'h08, v);
    chk("R8", "mode readback", v, 8'h3C);
    chk("R8", "pa_o unaffected", pa_o, drv(8'h5A, 8'hF0));
    chk("R8", "pc_o unaffected", pc_o, 8'h90);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    logic [7:0] a0, b0, c0;
    a0 = pa_o; b0 = pb_o; c0 = pc_o;
    wr(5'h1F, 8'hFF);
    chk("R9", "err after unmapped", {7'd0, last_err}, 8'h01);
    @(negedge clk);
    chk("R9", "err one cycle", {7'd0, err}, 8'h00);
    wr(5'h14, 8'hFF);
    chk("R9", "err on snapshot write", {7'd0, last_err}, 8'h01);
    rd(5'h14, v);
    chk("R9", "snapshot A unchanged", v, 8'h00);
    chk("R9", "pins unchanged A", pa_o, a0);
    chk("R9", "pins unchanged B", pb_o, b0);
    chk("R9", "pins unchanged C", pc_o, c0);
    rd(5'h08, v);
    chk("R9", "mode unchanged", v, 8'h3C);
    rd(5'h1F, v);
    chk("R9", "unmapped read", v, 8'h00);
    rd(5'h12, v);
    chk("R9", "set offset read", v, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_drive();
    t_dir_recompute();
    t_setclr();
    t_read();
    t_snap();
    t_mode();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule